// File: doc/BRIEF.md
# Interleaved Pipelined-SAR Converter Digital Back-End

This block is the digital back-end of a converter that is split into four time-interleaved sub-converter lanes. Together the four lanes give the full sample rate, so each lane runs at a quarter of the aggregate rate. Each lane is a two-stage pipelined successive-approximation converter. Its first stage returns a 4-bit coarse code and its second stage returns a 9-bit fine code. The redundancy in the raw codes makes the analog decisions tolerant of small errors.

For every lane the block adds the two stages with overlapping weights. It removes the mid-scale value and adds a per-lane signed digital offset. It then clamps the result to a signed 11-bit sample and raises a flag when it clamps. Each lane has a one-deep holding register. A sequencer drains these registers strictly in lane order 0,1,2,3, so the output stream keeps sample order even when lane results arrive with different latencies. Each output word comes with a one-cycle valid pulse and the index of the lane that produced it.

Top module: `adc_ilv_backend`

## Requirements
- R1: While reset is asserted, and for at least two cycles after `rst_n` rises, `out_vld` is 0 and no word is emitted. Reset clears all holding registers and all offsets to 0, and resets the expected lane to 0.
- R2: The raw lane value is coarse×128 plus the sum of the weights of the set fine bits. Fine bits 8 down to 0 weigh 128, 64, 32, 16, 8, 8, 4, 2, 1. The sample is the raw value minus 1088, taken as a two's-complement number on `out_data`.
- R3: Fine bits 4 and 3 both weigh 8, so setting both gives the same sample as setting only bit 5. Setting either one alone gives the same sample as setting the other alone.
- R4: The weight of the coarse LSB (128) equals the weight of the fine MSB. As a result, coarse c with fine 0 gives the same sample as coarse c−1 with only fine bit 8 set.
- R5: A value above 1023 is output as 1023, and a value below −1024 is output as −1024. In both cases `out_sat` is 1. Exactly 1023 or exactly −1024 is output with `out_sat` 0.
- R6: Each lane has an 8-bit signed offset, written by `cfg_we` with `cfg_lane` and `cfg_data`. The offset is added before clamping. A write applies to samples of that lane captured on later clock edges and leaves the other lanes unchanged.
- R7: Words leave in lane order 0,1,2,3,0,… A lane that arrives early is held until every earlier lane in that order has been emitted.
- R8: A lane captured on edge k, while it is the next lane due, appears at the output with `out_vld` set after edge k+1. `out_lane` gives the lane index. Held lanes drain one per cycle, and each `out_vld` pulse lasts one cycle per word.
- R9: The user delivers at most one sample per lane until that lane has been emitted. A new sample for a full lane is only allowed in the cycle in which that lane drains.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| lane_vld | input | 4 | One valid bit per lane for its coarse and fine codes |
| lane_coarse | input | 16 | 4-bit coarse codes; lane n occupies bits [4n+3:4n] |
| lane_fine | input | 36 | 9-bit fine codes; lane n occupies bits [9n+8:9n] |
| cfg_we | input | 1 | Offset write strobe |
| cfg_lane | input | 2 | Lane whose offset is written |
| cfg_data | input | 8 | Signed offset value |
| out_vld | output | 1 | One-cycle pulse per output word |
| out_data | output | 11 | Signed corrected sample |
| out_sat | output | 1 | Set when the word was clamped |
| out_lane | output | 2 | Lane that produced the word |

## Verification
A wrong weight or mid-scale constant shows as a wrong `out_data` on the word for that lane, one cycle after the lane is captured. The redundancy and overlap equalities expose a weight swap even when it happens to give a plausible value. A lost or stuck holding register or sequencer pointer shows at once: words come out of order, or `out_lane` skips, or the stream stalls. The bench makes this visible by delivering lanes out of order and confirming that nothing leaves until lane 0 arrives. An offset written to the wrong lane appears on the next sample of the affected lanes.

// File: rtl/adc_ilv_pkg.sv
package adc_ilv_pkg;
  // Weight of fine-stage bit idx; bit dup_idx repeats the weight of the bit above it.
  function automatic int fine_weight(input int idx, input int dup_idx);
    if (idx > dup_idx) return 1 << (idx - 1);
    return 1 << idx;
  endfunction
endpackage

// File: rtl/adc_stage_merge.sv
module adc_stage_merge
  import adc_ilv_pkg::*;
#(
  parameter int CRS_W   = 4,
  parameter int FIN_W   = 9,
  parameter int DUP_BIT = 3,
  parameter int OUT_W   = 11,
  parameter int OFS_W   = 8,
  parameter int MID     = 1088
) (
  input  logic [CRS_W-1:0] coarse,
  input  logic [FIN_W-1:0] fine,
  input  logic [OFS_W-1:0] ofs,
  output logic [OUT_W-1:0] val,
  output logic             sat
);
  localparam int SUM_W = OUT_W + 3;
  localparam logic signed [SUM_W-1:0] HI = SUM_W'((1 << (OUT_W - 1)) - 1);
  localparam logic signed [SUM_W-1:0] LO = -HI - SUM_W'(1);

  logic signed [SUM_W-1:0] acc;

  always_comb begin
    // coarse LSB sits on the fine MSB weight (one bit of overlap)
    acc = SUM_W'(coarse) << (FIN_W - 2);
    for (int i = 0; i < FIN_W; i++) begin
      if (fine[i]) acc = acc + SUM_W'(fine_weight(i, DUP_BIT));
    end
    acc = acc - SUM_W'(MID) + SUM_W'($signed(ofs));
    if (acc > HI) begin
      val = HI[OUT_W-1:0];
      sat = 1'b1;
    end else if (acc < LO) begin
      val = LO[OUT_W-1:0];
      sat = 1'b1;
    end else begin
      val = acc[OUT_W-1:0];
      sat = 1'b0;
    end
  end
endmodule

// File: rtl/adc_ofs_regs.sv
module adc_ofs_regs #(
  parameter int LANES = 4,
  parameter int OFS_W = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cfg_we,
  input  logic [$clog2(LANES)-1:0]    cfg_lane,
  input  logic [OFS_W-1:0]            cfg_data,
  output logic [LANES-1:0][OFS_W-1:0] ofs
);
  logic [LANES-1:0][OFS_W-1:0] ofs_d, ofs_q;

  always_comb begin
    ofs_d = ofs_q;
    if (cfg_we) ofs_d[cfg_lane] = cfg_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ofs_q <= '0;
    else        ofs_q <= ofs_d;
  end

  assign ofs = ofs_q;

  for (genvar g = 0; g < LANES; g++) begin : g_chk
    // R6: a write lands in the addressed lane only
    p_ofs_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_lane == g) |=> ofs_q[g] == $past(cfg_data));
    p_ofs_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_we || cfg_lane != g) |=> $stable(ofs_q[g]));
  end
endmodule

// File: rtl/adc_lane_hold.sv
module adc_lane_hold #(
  parameter int OUT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_vld,
  input  logic [OUT_W-1:0] in_val,
  input  logic             in_sat,
  input  logic             take,
  output logic             full,
  output logic [OUT_W-1:0] q_val,
  output logic             q_sat
);
  logic full_d, full_q;
  logic [OUT_W-1:0] val_q;
  logic sat_q;

  always_comb begin
    full_d = full_q;
    if (take)   full_d = 1'b0;
    if (in_vld) full_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      val_q  <= '0;
      sat_q  <= 1'b0;
    end else begin
      full_q <= full_d;
      if (in_vld) begin
        val_q <= in_val;
        sat_q <= in_sat;
      end
    end
  end

  assign full  = full_q;
  assign q_val = val_q;
  assign q_sat = sat_q;

  // R9: no new sample into a lane that still holds one and is not draining
  p_no_overrun_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && full_q) |-> take);
  // R8: only a held sample is taken
  p_take_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> full_q);
endmodule

// File: rtl/adc_lane_seq.sv
module adc_lane_seq #(
  parameter int LANES = 4,
  parameter int OUT_W = 11
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [LANES-1:0]            full,
  input  logic [LANES-1:0][OUT_W-1:0] hold_val,
  input  logic [LANES-1:0]            hold_sat,
  output logic [LANES-1:0]            take,
  output logic                        out_vld,
  output logic [OUT_W-1:0]            out_data,
  output logic                        out_sat,
  output logic [$clog2(LANES)-1:0]    out_lane
);
  localparam int LN_W = $clog2(LANES);
  localparam logic [LN_W-1:0] LAST = LN_W'(LANES - 1);

  logic [LN_W-1:0]  ptr_d, ptr_q, lane_q;
  logic             vld_d, vld_q, sat_q;
  logic [OUT_W-1:0] data_q;

  always_comb begin
    ptr_d = ptr_q;
    take  = '0;
    vld_d = 1'b0;
    if (full[ptr_q]) begin
      take[ptr_q] = 1'b1;
      vld_d       = 1'b1;
      ptr_d       = (ptr_q == LAST) ? '0 : ptr_q + LN_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      vld_q  <= 1'b0;
      data_q <= '0;
      sat_q  <= 1'b0;
      lane_q <= '0;
    end else begin
      ptr_q <= ptr_d;
      vld_q <= vld_d;
      if (vld_d) begin
        data_q <= hold_val[ptr_q];
        sat_q  <= hold_sat[ptr_q];
        lane_q <= ptr_q;
      end
    end
  end

  assign out_vld  = vld_q;
  assign out_data = data_q;
  assign out_sat  = sat_q;
  assign out_lane = lane_q;

  // checker state: lane of the previous emitted word
  logic [LN_W-1:0] chk_last_q, chk_next;
  assign chk_next = (chk_last_q == LAST) ? '0 : chk_last_q + LN_W'(1);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     chk_last_q <= LAST;
    else if (vld_q) chk_last_q <= lane_q;
  end

  // R7: words leave in strict lane order
  p_lane_order_r7: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |-> lane_q == chk_next);
  // R5: a clamped word sits on a range limit
  p_sat_limit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && sat_q) |-> (data_q == {1'b0, {(OUT_W-1){1'b1}}} ||
                          data_q == {1'b1, {(OUT_W-1){1'b0}}}));
endmodule

// File: rtl/adc_ilv_backend.sv
module adc_ilv_backend #(
  parameter int LANES   = 4,
  parameter int CRS_W   = 4,
  parameter int FIN_W   = 9,
  parameter int DUP_BIT = 3,
  parameter int OUT_W   = 11,
  parameter int OFS_W   = 8,
  parameter int MID     = 1088
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [LANES-1:0]           lane_vld,
  input  logic [LANES*CRS_W-1:0]     lane_coarse,
  input  logic [LANES*FIN_W-1:0]     lane_fine,
  input  logic                       cfg_we,
  input  logic [$clog2(LANES)-1:0]   cfg_lane,
  input  logic [OFS_W-1:0]           cfg_data,
  output logic                       out_vld,
  output logic [OUT_W-1:0]           out_data,
  output logic                       out_sat,
  output logic [$clog2(LANES)-1:0]   out_lane
);
  logic [1:0] rst_sync_q;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_q_n = rst_sync_q[1];

  logic [LANES-1:0][OFS_W-1:0] ofs;
  logic [LANES-1:0][OUT_W-1:0] m_val, h_val;
  logic [LANES-1:0]            m_sat, h_sat, full, take;

  adc_ofs_regs #(.LANES(LANES), .OFS_W(OFS_W)) u_ofs (
    .clk(clk), .rst_n(rst_q_n), .cfg_we(cfg_we), .cfg_lane(cfg_lane),
    .cfg_data(cfg_data), .ofs(ofs));

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    adc_stage_merge #(.CRS_W(CRS_W), .FIN_W(FIN_W), .DUP_BIT(DUP_BIT),
                      .OUT_W(OUT_W), .OFS_W(OFS_W), .MID(MID)) u_merge (
      .coarse(lane_coarse[g*CRS_W +: CRS_W]), .fine(lane_fine[g*FIN_W +: FIN_W]),
      .ofs(ofs[g]), .val(m_val[g]), .sat(m_sat[g]));

    adc_lane_hold #(.OUT_W(OUT_W)) u_hold (
      .clk(clk), .rst_n(rst_q_n), .in_vld(lane_vld[g]), .in_val(m_val[g]),
      .in_sat(m_sat[g]), .take(take[g]), .full(full[g]), .q_val(h_val[g]),
      .q_sat(h_sat[g]));
  end

  adc_lane_seq #(.LANES(LANES), .OUT_W(OUT_W)) u_seq (
    .clk(clk), .rst_n(rst_q_n), .full(full), .hold_val(h_val), .hold_sat(h_sat),
    .take(take), .out_vld(out_vld), .out_data(out_data), .out_sat(out_sat),
    .out_lane(out_lane));

  // R1: quiet while the internal reset is held
  p_reset_quiet_r1: assert property (@(posedge clk) !rst_q_n |=> !out_vld);
endmodule

// File: tb/test_adc_ilv_backend.sv
module test_adc_ilv_backend;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  lane_vld;
  logic [15:0] lane_coarse;
  logic [35:0] lane_fine;
  logic        cfg_we;
  logic [1:0]  cfg_lane;
  logic [7:0]  cfg_data;
  logic        out_vld;
  logic [10:0] out_data;
  logic        out_sat;
  logic [1:0]  out_lane;

  always #4 clk = ~clk;

  adc_ilv_backend i_adc_ilv_backend (
    .clk(clk), .rst_n(rst_n), .lane_vld(lane_vld), .lane_coarse(lane_coarse),
    .lane_fine(lane_fine), .cfg_we(cfg_we), .cfg_lane(cfg_lane), .cfg_data(cfg_data),
    .out_vld(out_vld), .out_data(out_data), .out_sat(out_sat), .out_lane(out_lane));

  int n_chk = 0, n_bad = 0, cap_n = 0;
  int cap_d[256], cap_s[256], cap_l[256];
  int ofs_m[4] = '{0, 0, 0, 0};

  always @(negedge clk) begin
    if (out_vld && cap_n < 256) begin
      cap_d[cap_n] = int'($signed(out_data));
      cap_s[cap_n] = int'(out_sat);
      cap_l[cap_n] = int'(out_lane);
      cap_n++;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int raw_of(input int c, input int f);
    int w[9] = '{1, 2, 4, 8, 8, 16, 32, 64, 128};
    int r = c * 128;
    for (int i = 0; i < 9; i++) if (((f >> i) & 1) == 1) r += w[i];
    return r;
  endfunction

  function automatic int ref_val(input int c, input int f, input int o);
    int v = raw_of(c, f) - 1088 + o;
    if (v > 1023) return 1023;
    if (v < -1024) return -1024;
    return v;
  endfunction

  function automatic int ref_sat(input int c, input int f, input int o);
    int v = raw_of(c, f) - 1088 + o;
    return (v > 1023 || v < -1024) ? 1 : 0;
  endfunction

  task automatic send(input int ln, input int c, input int f);
    @(negedge clk);
    lane_vld = '0;
    lane_vld[ln] = 1'b1;
    lane_coarse[ln*4 +: 4] = 4'(c);
    lane_fine[ln*9 +: 9]   = 9'(f);
    @(negedge clk);
    lane_vld = '0;
  endtask

  task automatic wr_ofs(input int ln, input int v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_lane = 2'(ln); cfg_data = 8'(v);
    @(negedge clk);
    cfg_we = 1'b0;
    ofs_m[ln] = v;
  endtask

  task automatic check_entry(input string req, input int idx, input int ln,
                             input int c, input int f);
    chk(req, "lane", cap_l[idx], ln);
    chk(req, "data", cap_d[idx], ref_val(c, f, ofs_m[ln]));
    chk(req, "sat",  cap_s[idx], ref_sat(c, f, ofs_m[ln]));
  endtask

  task automatic burst(input string req, input int c0, input int f0, input int c1,
                       input int f1, input int c2, input int f2, input int c3, input int f3);
    int start = cap_n;
    int cs[4];
    int fs[4];
    cs = '{c0, c1, c2, c3};
    fs = '{f0, f1, f2, f3};
    for (int l = 0; l < 4; l++) send(l, cs[l], fs[l]);
    repeat (4) @(negedge clk);
    chk(req, "word count", cap_n - start, 4);
    for (int l = 0; l < 4; l++) check_entry(req, start + l, l, cs[l], fs[l]);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R1", "out_vld after reset", int'(out_vld), 0);
    chk("R1", "words after reset", cap_n, 0);
  endtask

  task automatic t_merge();
    burst("R2", 8, 9'h040, 3, 9'h005, 12, 9'h100, 10, 9'h0AA);
  endtask

  task automatic t_dup();
    burst("R3", 8, 9'b000011000, 8, 9'b000100000, 8, 9'b000001000, 8, 9'b000010000);
    chk("R3", "bits4+3 equal bit5", cap_d[cap_n-4], cap_d[cap_n-3]);
    chk("R3", "bit3 equals bit4", cap_d[cap_n-2], cap_d[cap_n-1]);
  endtask

  task automatic t_overlap();
    burst("R4", 9, 9'h000, 8, 9'h100, 7, 9'h1FF, 5, 9'h000);
    chk("R4", "coarse LSB equals fine MSB", cap_d[cap_n-4], cap_d[cap_n-3]);
  endtask

  task automatic t_clamp();
    burst("R5", 15, 9'h1FF, 0, 9'h000, 15, 9'b101110111, 0, 9'h080);
  endtask

  task automatic t_offset();
    wr_ofs(1, -5);
    wr_ofs(2, 100);
    wr_ofs(3, -128);
    burst("R6", 8, 9'h040, 8, 9'h040, 8, 9'h040, 8, 9'h040);
    burst("R6", 8, 9'h040, 0, 9'h080, 15, 9'b101110111, 2, 9'h000);
    wr_ofs(1, 0); wr_ofs(2, 0); wr_ofs(3, 0);
  endtask

  task automatic t_order();
    int start = cap_n;
    send(3, 11, 9'h013);
    send(1, 4, 9'h1C0);
    send(2, 9, 9'h001);
    repeat (3) @(negedge clk);
    chk("R7", "held until lane 0", cap_n - start, 0);
    send(0, 6, 9'h0F0);
    chk("R8", "not yet valid", int'(out_vld), 0);
    for (int l = 0; l < 4; l++) begin
      @(negedge clk);
      chk("R8", "valid on consecutive cycles", int'(out_vld), 1);
      chk("R7", "lane sequence", int'(out_lane), l);
    end
    @(negedge clk);
    chk("R8", "pulse ends", int'(out_vld), 0);
    check_entry("R7", start + 0, 0, 6, 9'h0F0);
    check_entry("R7", start + 1, 1, 4, 9'h1C0);
    check_entry("R7", start + 2, 2, 9, 9'h001);
    check_entry("R7", start + 3, 3, 11, 9'h013);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; lane_vld = '0; lane_coarse = '0; lane_fine = '0;
    cfg_we = 1'b0; cfg_lane = '0; cfg_data = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "out_vld in reset", int'(out_vld), 0);
    rst_n = 1'b1;
    t_reset();
    t_merge();
    t_dup();
    t_overlap();
    t_clamp();
    t_offset();
    t_order();
    t_merge();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule